// File: doc/BRIEF.md
# Programmable Digital Cellular Neural Network Grid

This block is a small rectangular grid of identical discrete-time cells. Each cell holds one binary input pixel, a signed multi-bit state and a one-bit output. A cell exchanges values only with its four nearest neighbours. Every cell uses the same template: one feedback weight and one control weight for each of the five taps (itself and the four neighbours), plus a bias constant. A host writes the template and the iteration count through a configuration port, so one grid can run different pixel-level image operations from frame to frame.

A frame begins with a start pulse. The pixels then stream in one at a time in raster order. The grid runs the programmed number of iterations and then streams its outputs back in the same order. Each iteration has two phases. In the first phase every cell forms one partial sum per tap, one tap per cycle, and stores each sum locally. In the second phase the cell adds the five stored sums and the bias and writes the result to its state in a single cycle. The cell output is the sign bit of the state.

Top module: `cnn_grid`

## Requirements
- R1: After each iteration a cell's state is C + Σ over its five taps of (y_k ? a_k : 0) + (u_k ? b_k : 0). The weights and C are 4-bit two's complement and the state is 8-bit two's complement. The sum saturates to [-128, 127]. The output y is 1 exactly when the state is negative.
- R2: Configuration addresses: a for taps self, north, east, south, west at 0–4; b for the same taps at 5–9; C at 10; iteration count (8 bits) at 11. Weights and C take wdata bits [3:0]. North is the row above and row 0 is the top row.
- R3: A neighbour outside the grid contributes output 0 and input 0.
- R4: Each iteration takes exactly 6 cycles: five cycles of partial-sum generation, one per tap in the order self, north, east, south, west, followed by one accumulation cycle. Generation and accumulation never overlap. Cell state changes only during accumulation or when a frame starts.
- R5: After a start pulse is accepted, pix_in_ready is high until the grid has accepted ROWS*COLS pixels in raster order (row 0 column 0 first). A pixel is accepted when pix_in_valid and pix_in_ready are both high at a clock edge. pix_in_ready is low at all other times.
- R6: After the last iteration, pix_out_valid stays high until ROWS*COLS outputs have left in raster order. A transfer happens on valid and ready. While valid is high and ready is low, the data is held.
- R7: Configuration writes are ignored while busy is high. After reset all weights and C are zero.
- R8: The iteration count resets to 100. With a count of 0, the readout follows the load directly and gives all-zero outputs, because state is cleared at the start of each frame.
- R9: start is accepted only while the grid is idle. busy is high from the accepted start until the last output transfer. done goes high after the last transfer and stays high until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Configuration address |
| cfg_wdata | input | 8 | Configuration write data |
| start | input | 1 | Frame start pulse |
| pix_in_valid | input | 1 | Input pixel valid |
| pix_in_ready | output | 1 | Grid accepts an input pixel |
| pix_in_data | input | 1 | Input pixel bit |
| pix_out_valid | output | 1 | Output pixel valid |
| pix_out_ready | input | 1 | Consumer accepts an output pixel |
| pix_out_data | output | 1 | Output pixel bit |
| busy | output | 1 | A frame is in progress |
| done | output | 1 | Last frame's readout completed |

## Verification
The assertions assume that reset is applied before the first frame and that a consumer which lowers pix_out_ready expects the same bit when it raises ready again. They also assume that configuration changes are meant to take effect only between frames. The stimulus deliberately violates the last point: it writes a template and a different iteration count, and pulses start, in the middle of a frame. It then checks both that frame and the next one against the old settings. Input valid and output ready are toggled in fixed gap patterns so that stalls occur on both streams. Expected outputs come from an arithmetic model in the bench. The model is run over a sweep of generated templates and images and over single-tap templates that isolate each neighbour and each border.

// File: rtl/cnn_pkg.sv
package cnn_pkg;
  localparam int NBR = 5;

  typedef enum logic [2:0] {
    TAP_SELF  = 3'd0,
    TAP_NORTH = 3'd1,
    TAP_EAST  = 3'd2,
    TAP_SOUTH = 3'd3,
    TAP_WEST  = 3'd4
  } tap_e;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_LOAD,
    PH_GEN,
    PH_ACC,
    PH_READ
  } phase_e;

  localparam int ADDR_BIAS = 10;
  localparam int ADDR_ITER = 11;
endpackage

// File: rtl/cnn_tmpl_regs.sv
module cnn_tmpl_regs
  import cnn_pkg::*;
#(
  parameter int TW       = 4,
  parameter int CDW      = 8,
  parameter int AW       = 4,
  parameter int ITW      = 8,
  parameter int ITER_RST = 100
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               lock,
  input  logic               we,
  input  logic [AW-1:0]      addr,
  input  logic [CDW-1:0]     wdata,
  output logic [NBR*TW-1:0]  a_flat,
  output logic [NBR*TW-1:0]  b_flat,
  output logic [TW-1:0]      c_val,
  output logic [ITW-1:0]     iter_lim
);
  logic wr_ok;
  logic [TW-1:0] a_q [NBR];
  logic [TW-1:0] b_q [NBR];

  assign wr_ok = we && !lock;

  for (genvar k = 0; k < NBR; k++) begin : g_tap
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        a_q[k] <= '0;
        b_q[k] <= '0;
      end else if (wr_ok) begin
        if (addr == AW'(k))       a_q[k] <= wdata[TW-1:0];
        if (addr == AW'(NBR + k)) b_q[k] <= wdata[TW-1:0];
      end
    end
    assign a_flat[k*TW +: TW] = a_q[k];
    assign b_flat[k*TW +: TW] = b_q[k];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c_val    <= '0;
      iter_lim <= ITW'(ITER_RST);
    end else if (wr_ok) begin
      if (addr == AW'(ADDR_BIAS)) c_val    <= wdata[TW-1:0];
      if (addr == AW'(ADDR_ITER)) iter_lim <= wdata[ITW-1:0];
    end
  end

  // R7: a locked template file keeps every value
  p_tmpl_locked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    lock |=> ($stable(a_flat) && $stable(b_flat) && $stable(c_val) && $stable(iter_lim)));
endmodule

// File: rtl/cnn_cell.sv
module cnn_cell
  import cnn_pkg::*;
#(
  parameter int TW = 4,
  parameter int SW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              load_en,
  input  logic              load_bit,
  input  logic              gen_en,
  input  logic [2:0]        gen_sel,
  input  logic              acc_en,
  input  logic [NBR*TW-1:0] a_flat,
  input  logic [NBR*TW-1:0] b_flat,
  input  logic [TW-1:0]     c_val,
  input  logic [NBR-1:0]    nbr_y,
  input  logic [NBR-1:0]    nbr_u,
  output logic              y_o,
  output logic              u_o
);
  localparam int PW   = TW + 1;
  localparam int SUMW = ((TW + 5) > (SW + 1)) ? (TW + 5) : (SW + 1);
  localparam int SMAX = (1 << (SW - 1)) - 1;
  localparam int SMIN = -(1 << (SW - 1));

  logic                    u_q;
  logic [SW-1:0]           st_q;
  logic [SW-1:0]           st_nx;
  logic [NBR-1:0][PW-1:0]  ps_q;
  logic [TW-1:0]           a_raw, b_raw;
  logic signed [PW-1:0]    a_ext, b_ext, ps_nx;
  logic signed [SUMW-1:0]  tot;

  // partial sum for the tap chosen this cycle
  always_comb begin
    a_raw = a_flat[int'(gen_sel)*TW +: TW];
    b_raw = b_flat[int'(gen_sel)*TW +: TW];
    a_ext = {a_raw[TW-1], a_raw};
    b_ext = {b_raw[TW-1], b_raw};
    ps_nx = (nbr_y[gen_sel] ? a_ext : '0) + (nbr_u[gen_sel] ? b_ext : '0);
  end

  // accumulation of the stored sums and bias, saturated to state width
  always_comb begin
    tot = SUMW'($signed(c_val));
    for (int k = 0; k < NBR; k++) tot = tot + SUMW'($signed(ps_q[k]));
    if (tot > signed'(SUMW'(SMAX)))      st_nx = SW'(SMAX);
    else if (tot < signed'(SUMW'(SMIN))) st_nx = SW'(SMIN);
    else                                 st_nx = tot[SW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= '0;
      u_q  <= 1'b0;
      ps_q <= '0;
    end else begin
      if (clr)         st_q <= '0;
      else if (acc_en) st_q <= st_nx;
      if (load_en) u_q <= load_bit;
      if (gen_en)  ps_q[gen_sel] <= ps_nx;
    end
  end

  assign y_o = st_q[SW-1];
  assign u_o = u_q;

  // R4: state moves only on accumulation or frame clear
  p_state_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_en && !clr) |=> $stable(st_q));
  // R4: stored partial sums are untouched while accumulating
  p_psum_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    acc_en |=> $stable(ps_q));
endmodule

// File: rtl/cnn_seq.sv
module cnn_seq
  import cnn_pkg::*;
#(
  parameter int NCELL = 16,
  parameter int ITW   = 8,
  localparam int IDXW = (NCELL > 1) ? $clog2(NCELL) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [ITW-1:0]  iter_lim,
  input  logic            in_valid,
  input  logic            out_ready,
  output logic            in_ready,
  output logic            out_valid,
  output logic            load_fire,
  output logic [IDXW-1:0] idx,
  output logic            gen_en,
  output logic [2:0]      gen_sel,
  output logic            acc_en,
  output logic            clr,
  output logic            busy,
  output logic            done
);
  phase_e          ph_q;
  logic [IDXW-1:0] idx_q;
  logic [2:0]      sel_q;
  logic [ITW-1:0]  it_q;
  logic            done_q;
  logic            last_idx;

  assign last_idx = (idx_q == IDXW'(NCELL - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      idx_q  <= '0;
      sel_q  <= '0;
      it_q   <= '0;
      done_q <= 1'b0;
    end else begin
      case (ph_q)
        PH_IDLE: if (start) begin
          ph_q   <= PH_LOAD;
          idx_q  <= '0;
          done_q <= 1'b0;
        end
        PH_LOAD: if (in_valid) begin
          if (last_idx) begin
            idx_q <= '0;
            sel_q <= '0;
            it_q  <= '0;
            ph_q  <= (iter_lim == '0) ? PH_READ : PH_GEN;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        PH_GEN: begin
          if (sel_q == 3'(TAP_WEST)) begin
            sel_q <= '0;
            ph_q  <= PH_ACC;
          end else begin
            sel_q <= sel_q + 3'd1;
          end
        end
        PH_ACC: begin
          if (ITW'(it_q + 1'b1) == iter_lim) begin
            ph_q <= PH_READ;
          end else begin
            it_q <= it_q + 1'b1;
            ph_q <= PH_GEN;
          end
        end
        PH_READ: if (out_ready) begin
          if (last_idx) begin
            idx_q  <= '0;
            ph_q   <= PH_IDLE;
            done_q <= 1'b1;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  assign in_ready  = (ph_q == PH_LOAD);
  assign out_valid = (ph_q == PH_READ);
  assign load_fire = in_ready && in_valid;
  assign idx       = idx_q;
  assign gen_en    = (ph_q == PH_GEN);
  assign gen_sel   = sel_q;
  assign acc_en    = (ph_q == PH_ACC);
  assign clr       = (ph_q == PH_IDLE) && start;
  assign busy      = (ph_q != PH_IDLE);
  assign done      = done_q;

  // R4: the two phases are disjoint
  p_phase_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(gen_en && acc_en));
  // R4: accumulation follows the last tap directly
  p_acc_after_west_r4: assert property (@(posedge clk) disable iff (!rst_n)
    acc_en |-> ($past(gen_en) && $past(gen_sel) == 3'(TAP_WEST)));
  // R6: a stalled output keeps its position
  p_out_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(idx)));
  // R8: iteration index stays under the limit while computing
  p_iter_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (gen_en || acc_en) |-> (it_q < iter_lim));
  // R9: done and busy never both high
  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
endmodule

// File: rtl/cnn_grid.sv
module cnn_grid
  import cnn_pkg::*;
#(
  parameter int ROWS     = 4,
  parameter int COLS     = 4,
  parameter int TW       = 4,
  parameter int SW       = 8,
  parameter int AW       = 4,
  parameter int CDW      = 8,
  parameter int ITW      = 8,
  parameter int ITER_RST = 100
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_we,
  input  logic [AW-1:0]  cfg_addr,
  input  logic [CDW-1:0] cfg_wdata,
  input  logic           start,
  input  logic           pix_in_valid,
  output logic           pix_in_ready,
  input  logic           pix_in_data,
  output logic           pix_out_valid,
  input  logic           pix_out_ready,
  output logic           pix_out_data,
  output logic           busy,
  output logic           done
);
  localparam int NCELL = ROWS * COLS;
  localparam int IDXW  = (NCELL > 1) ? $clog2(NCELL) : 1;

  logic [NBR*TW-1:0] a_flat, b_flat;
  logic [TW-1:0]     c_val;
  logic [ITW-1:0]    iter_lim;
  logic              load_fire, gen_en, acc_en, clr;
  logic [2:0]        gen_sel;
  logic [IDXW-1:0]   idx;
  logic [NCELL-1:0]  y_vec, u_vec;
  logic [NBR-1:0]    ny [NCELL];
  logic [NBR-1:0]    nu [NCELL];

  cnn_tmpl_regs #(
    .TW(TW), .CDW(CDW), .AW(AW), .ITW(ITW), .ITER_RST(ITER_RST)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .lock(busy), .we(cfg_we), .addr(cfg_addr),
    .wdata(cfg_wdata), .a_flat(a_flat), .b_flat(b_flat), .c_val(c_val),
    .iter_lim(iter_lim)
  );

  cnn_seq #(.NCELL(NCELL), .ITW(ITW)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .iter_lim(iter_lim),
    .in_valid(pix_in_valid), .out_ready(pix_out_ready),
    .in_ready(pix_in_ready), .out_valid(pix_out_valid), .load_fire(load_fire),
    .idx(idx), .gen_en(gen_en), .gen_sel(gen_sel), .acc_en(acc_en),
    .clr(clr), .busy(busy), .done(done)
  );

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar c = 0; c < COLS; c++) begin : g_col
      localparam int ID = r * COLS + c;

      assign ny[ID][TAP_SELF] = y_vec[ID];
      assign nu[ID][TAP_SELF] = u_vec[ID];
      if (r > 0) begin : g_n
        assign ny[ID][TAP_NORTH] = y_vec[ID-COLS];
        assign nu[ID][TAP_NORTH] = u_vec[ID-COLS];
      end else begin : g_n0
        assign ny[ID][TAP_NORTH] = 1'b0;
        assign nu[ID][TAP_NORTH] = 1'b0;
      end
      if (c < COLS - 1) begin : g_e
        assign ny[ID][TAP_EAST] = y_vec[ID+1];
        assign nu[ID][TAP_EAST] = u_vec[ID+1];
      end else begin : g_e0
        assign ny[ID][TAP_EAST] = 1'b0;
        assign nu[ID][TAP_EAST] = 1'b0;
      end
      if (r < ROWS - 1) begin : g_s
        assign ny[ID][TAP_SOUTH] = y_vec[ID+COLS];
        assign nu[ID][TAP_SOUTH] = u_vec[ID+COLS];
      end else begin : g_s0
        assign ny[ID][TAP_SOUTH] = 1'b0;
        assign nu[ID][TAP_SOUTH] = 1'b0;
      end
      if (c > 0) begin : g_w
        assign ny[ID][TAP_WEST] = y_vec[ID-1];
        assign nu[ID][TAP_WEST] = u_vec[ID-1];
      end else begin : g_w0
        assign ny[ID][TAP_WEST] = 1'b0;
        assign nu[ID][TAP_WEST] = 1'b0;
      end

      cnn_cell #(.TW(TW), .SW(SW)) u_cell (
        .clk(clk), .rst_n(rst_n), .clr(clr),
        .load_en(load_fire && (idx == IDXW'(ID))), .load_bit(pix_in_data),
        .gen_en(gen_en), .gen_sel(gen_sel), .acc_en(acc_en),
        .a_flat(a_flat), .b_flat(b_flat), .c_val(c_val),
        .nbr_y(ny[ID]), .nbr_u(nu[ID]),
        .y_o(y_vec[ID]), .u_o(u_vec[ID])
      );
    end
  end

  assign pix_out_data = y_vec[idx];

  // R6: held output data while the consumer stalls
  p_out_data_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_out_valid && !pix_out_ready) |=> $stable(pix_out_data));
  // R5: load and readout never overlap
  p_io_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pix_in_ready |-> !pix_out_valid);
endmodule

// File: tb/tb_cnn_grid.sv
`timescale 1ns/1ps
module tb_cnn_grid;
  localparam int ROWS = 4;
  localparam int COLS = 4;
  localparam int NC   = ROWS * COLS;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [3:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic       start = 1'b0;
  logic       pix_in_valid = 1'b0;
  logic       pix_in_ready;
  logic       pix_in_data = 1'b0;
  logic       pix_out_valid;
  logic       pix_out_ready = 1'b0;
  logic       pix_out_data;
  logic       busy, done;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  int ta [5];
  int tb [5];
  int tc;
  bit img [NC];
  bit ry  [NC];
  int dr [5] = '{0, -1, 0, 1, 0};
  int dc [5] = '{0, 0, 1, 0, -1};

  always #2 clk = ~clk;

  cnn_grid dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .start(start), .pix_in_valid(pix_in_valid),
    .pix_in_ready(pix_in_ready), .pix_in_data(pix_in_data),
    .pix_out_valid(pix_out_valid), .pix_out_ready(pix_out_ready),
    .pix_out_data(pix_out_data), .busy(busy), .done(done)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  task automatic cfg_write(input int addr, input int data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 4'(addr); cfg_wdata = 8'(data);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic set_tmpl(input int a [5], input int b [5], input int c);
    for (int k = 0; k < 5; k++) begin
      ta[k] = a[k]; tb[k] = b[k];
      cfg_write(k, a[k] & 15);
      cfg_write(5 + k, b[k] & 15);
    end
    tc = c;
    cfg_write(10, c & 15);
  endtask

  function automatic void model_run(input int iters);
    bit nyv [NC];
    for (int i = 0; i < NC; i++) ry[i] = 0;
    for (int it = 0; it < iters; it++) begin
      for (int r = 0; r < ROWS; r++) begin
        for (int c = 0; c < COLS; c++) begin
          int x = tc;
          for (int k = 0; k < 5; k++) begin
            int rr = r + dr[k];
            int cc = c + dc[k];
            if (rr >= 0 && rr < ROWS && cc >= 0 && cc < COLS) begin
              if (ry[rr*COLS+cc])  x += ta[k];
              if (img[rr*COLS+cc]) x += tb[k];
            end
          end
          if (x > 127) x = 127;
          if (x < -128) x = -128;
          nyv[r*COLS+c] = (x < 0);
        end
      end
      for (int i = 0; i < NC; i++) ry[i] = nyv[i];
    end
  endfunction

  // one full frame; poke = disturb config and start while computing
  task automatic run_frame(input int iters, input string tag, input bit poke);
    int cnt;
    int g;
    int i;
    bit held;
    bit hv;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy === 1'b1 && done === 1'b0, "R9 busy after start", int'(busy), 1);
    i = 0; g = 0;
    while (i < NC) begin
      @(negedge clk);
      pix_in_valid = ((g % 4) != 3);
      pix_in_data  = img[i];
      g++;
      if (pix_in_valid && pix_in_ready) i++;
    end
    @(negedge clk);
    pix_in_valid = 1'b0;
    cnt = 0;
    while (!pix_out_valid) begin
      cnt++;
      if (poke && cnt == 2) begin
        start = 1'b1; cfg_we = 1'b1; cfg_addr = 4'd11; cfg_wdata = 8'(iters + 3);
      end else if (poke && cnt == 3) begin
        start = 1'b0; cfg_addr = 4'd0; cfg_wdata = 8'((ta[0] + 5) & 15);
      end else begin
        start = 1'b0; cfg_we = 1'b0;
      end
      @(negedge clk);
    end
    start = 1'b0; cfg_we = 1'b0;
    check(cnt == 6 * iters, "R4/R8 compute cycles", cnt, 6 * iters);
    model_run(iters);
    i = 0; g = 0; held = 0; hv = 0;
    while (i < NC) begin
      pix_out_ready = ((g % 3) != 1);
      g++;
      if (pix_out_valid) begin
        if (held) check(pix_out_data === hv, "R6 held data", int'(pix_out_data), int'(hv));
        held = !pix_out_ready;
        hv = pix_out_data;
        if (pix_out_ready) begin
          check(pix_out_data === ry[i], tag, int'(pix_out_data), int'(ry[i]));
          i++;
        end
      end
      @(negedge clk);
    end
    pix_out_ready = 1'b0;
    check(done === 1'b1 && busy === 1'b0, "R9 done after readout", int'(done), 1);
    check(pix_in_ready === 1'b0, "R5 ready low when idle", int'(pix_in_ready), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog R9 actual=expired expected=finish");
      report();
    end
  end

  initial begin
    int za [5];
    int zb [5];
    for (int k = 0; k < 5; k++) begin ta[k] = 0; tb[k] = 0; end
    tc = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy === 1'b0, "R9 reset busy", int'(busy), 0);
    check(done === 1'b0, "R9 reset done", int'(done), 0);
    check(pix_in_ready === 1'b0, "R5 reset ready", int'(pix_in_ready), 0);
    check(pix_out_valid === 1'b0, "R6 reset valid", int'(pix_out_valid), 0);

    // R8 default count 100, R7 zero templates give zero outputs
    for (int i = 0; i < NC; i++) img[i] = (i % 3) == 0;
    run_frame(100, "R7/R8 default frame", 0);

    // R8 count zero: outputs zero regardless of template
    for (int k = 0; k < 5; k++) begin za[k] = -1; zb[k] = -8; end
    set_tmpl(za, zb, -1);
    cfg_write(11, 0);
    run_frame(0, "R8 zero iterations", 0);

    // R2/R3: single control tap isolates each neighbour and the border
    cfg_write(11, 1);
    for (int k = 0; k < 5; k++) begin
      for (int j = 0; j < 5; j++) begin za[j] = 0; zb[j] = (j == k) ? 7 : 0; end
      set_tmpl(za, zb, -1);
      for (int i = 0; i < NC; i++) img[i] = ((i * 5 + k) % 3) != 0;
      run_frame(1, "R2/R3 single tap", 0);
    end

    // R1: sweep of generated templates, images and iteration counts
    for (int cf = 0; cf < 12; cf++) begin
      int it = 1 + (cf % 4);
      for (int k = 0; k < 5; k++) begin
        za[k] = ((cf * 7 + k * 3 + 1) % 16) - 8;
        zb[k] = ((cf * 5 + k * 11 + 4) % 16) - 8;
      end
      set_tmpl(za, zb, ((cf * 9 + 2) % 16) - 8);
      cfg_write(11, it);
      for (int i = 0; i < NC; i++) img[i] = ((i * (cf + 3) + cf) % 5) < 2;
      run_frame(it, "R1 sweep output", 0);
    end

    // R7/R9: writes and start while busy are ignored, also on the next frame
    for (int k = 0; k < 5; k++) begin za[k] = (k == 0) ? -6 : 2; zb[k] = (k % 2 == 0) ? 3 : -4; end
    set_tmpl(za, zb, 1);
    cfg_write(11, 2);
    for (int i = 0; i < NC; i++) img[i] = (i % 2) == (i / 4 % 2);
    run_frame(2, "R7 busy write frame", 1);
    run_frame(2, "R7 next frame", 0);

    finished = 1;
    report();
  end
endmodule